// File: doc/BRIEF.md
# Synchronizing Two-Wire Bus Clock Generator

This block produces the clock line timing for one master on an open-drain, wired-AND two-wire serial bus. Other masters and stretching slaves share that bus. The block never drives the line high. It only requests a pull-low, and a pad outside the block turns that request into an open-drain driver. The bus level is low whenever any device on the bus pulls it low.

The block reads back the sampled bus clock level and passes it through a two-flop synchronizer. Its phase counters restart from the edges it actually observes on the bus, not from its own requests. As a result, a slave that holds the line low makes the block wait without any time limit. Another master that drops the line early makes the block follow that fall at once. The combined clock therefore has the shortest high phase and the longest low phase among all the masters.

The block also emits single-cycle strobes on each observed rising edge and each observed falling edge. A neighbouring bit engine uses the rising strobe to sample data and the falling strobe to change data.

Top module: `scl_sync_gen`

## Requirements
- R1: While reset is active and immediately after it is released, `scl_pull_low` is 0 (bit value 1 means "drive the line low") and both strobes are 0.
- R2: `rise_stb` is high for exactly one cycle for each low-to-high transition of the synchronized bus level, and `fall_stb` is high for exactly one cycle for each high-to-low transition. The two strobes are never high together.
- R3: After the cycle in which `rise_stb` is seen, `scl_pull_low` stays 0 for exactly `high_cnt` clock cycles and then goes to 1, as long as no other device pulls the line low first.
- R4: After the cycle in which `fall_stb` is seen, `scl_pull_low` stays 1 for exactly `low_cnt` clock cycles and then returns to 0. This count is measured from the observed fall and not from the block's own request.
- R5: Once the block has released the line, it keeps `scl_pull_low` at 0 and raises no strobe for as long as the bus reads low, however long that lasts.
- R6: When another device stretches the low phase, the next high phase that the block times is still exactly `high_cnt` cycles.
- R7: If the bus falls while the block is timing its own high phase, the block sets `scl_pull_low` to 1 in the cycle after `fall_stb`. It then times a full `low_cnt` low phase from that fall.
- R8: When `enable` is 0, `scl_pull_low` is 0 from the next cycle on, and both strobes stay 0 whatever the bus does. After `enable` returns to 1 with the bus high, the next pull-low comes exactly `high_cnt` cycles later, because the counters restart from zero.
- R9: A `high_cnt` or `low_cnt` value of 0 behaves as a count of 1 cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Clock generation enable |
| scl_in | input | 1 | Sampled bus clock level, asynchronous to clk |
| high_cnt | input | CNT_W | Length of the high phase in clk cycles |
| low_cnt | input | CNT_W | Length of the low phase in clk cycles |
| scl_pull_low | output | 1 | 1 requests that the pad pull the clock line low |
| rise_stb | output | 1 | One-cycle strobe on an observed rising bus edge |
| fall_stb | output | 1 | One-cycle strobe on an observed falling bus edge |

## Verification
The bench builds the block with `CNT_W` set to 6 and the default two synchronizer stages. This lets it drive the largest count, 63, and the zero count that is treated as 1, within the same short run. The bench models a second bus device as an extra pull-low term in the wired-AND. With that device it stretches the low phase, cuts the high phase short, and toggles the line while the block is disabled. In each case it checks the phase lengths counted from the observed strobes.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  // Phase of the local clock generator.
  typedef enum logic [1:0] {
    PH_WAIT_HI = 2'd0,  // released, waiting for the bus to read high
    PH_HIGH    = 2'd1,  // released, timing the high phase
    PH_HOLD    = 2'd2,  // pulling low, waiting to observe the fall
    PH_LOW     = 2'd3   // pulling low, timing the low phase
  } scl_phase_e;

  function automatic logic phase_drives_low(scl_phase_e ph);
    return (ph == PH_HOLD) || (ph == PH_LOW);
  endfunction

  function automatic logic phase_counts(scl_phase_e ph);
    return (ph == PH_HIGH) || (ph == PH_LOW);
  endfunction

endpackage

// File: rtl/scl_edge_sync.sv
module scl_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic level,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              last_level;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= line_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], line_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_level <= 1'b1;
    else        last_level <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~last_level;
  assign fall  = ~level & last_level;

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);  // R2
  AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);  // R2

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         done
);

  logic [W-1:0] cnt;

  // A zero limit is treated as one cycle.
  function automatic logic [W:0] eff_limit(logic [W-1:0] v);
    return (v == '0) ? (W+1)'(1) : {1'b0, v};
  endfunction

  function automatic logic reached(logic [W-1:0] c, logic [W-1:0] v);
    return ({1'b0, c} + (W+1)'(1)) >= eff_limit(v);
  endfunction

  assign done = reached(cnt, limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clear)         cnt <= '0;
    else if (run && !done)  cnt <= cnt + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> cnt >= $past(cnt));  // R3
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && done && !clear) |=> $stable(cnt));  // R4

endmodule

// File: rtl/scl_sync_gen.sv
module scl_sync_gen #(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic [CNT_W-1:0] low_cnt,
  output logic             scl_pull_low,
  output logic             rise_stb,
  output logic             fall_stb
);
  import scl_gen_pkg::*;

  scl_phase_e       phase, phase_nx;
  logic             bus_hi, bus_rise, bus_fall;
  logic             tmr_clear, tmr_run, tmr_done;
  logic [CNT_W-1:0] tmr_limit;

  scl_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (scl_in),
    .level   (bus_hi),
    .rise    (bus_rise),
    .fall    (bus_fall)
  );

  assign tmr_limit = (phase == PH_LOW) ? low_cnt : high_cnt;
  assign tmr_run   = phase_counts(phase);

  scl_phase_timer #(.W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (tmr_clear),
    .run   (tmr_run),
    .limit (tmr_limit),
    .done  (tmr_done)
  );

  // An observed fall always starts a low phase, whoever caused it.
  always_comb begin
    phase_nx = phase;
    if (!enable) begin
      phase_nx = PH_WAIT_HI;
    end else if (bus_fall) begin
      phase_nx = PH_LOW;
    end else begin
      case (phase)
        PH_WAIT_HI: if (bus_hi)   phase_nx = PH_HIGH;
        PH_HIGH:    if (tmr_done) phase_nx = PH_HOLD;
        PH_HOLD:    phase_nx = PH_HOLD;
        PH_LOW:     if (tmr_done) phase_nx = PH_WAIT_HI;
        default:    phase_nx = PH_WAIT_HI;
      endcase
    end
  end

  assign tmr_clear = !enable || bus_fall || (phase_nx != phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_WAIT_HI;
    else        phase <= phase_nx;
  end

  assign scl_pull_low = phase_drives_low(phase);
  assign rise_stb     = enable & bus_rise;
  assign fall_stb     = enable & bus_fall;

  AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !scl_pull_low);  // R8
  AST_FALL_TAKES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && bus_fall) |=> (scl_pull_low && phase == PH_LOW));  // R7
  AST_WAIT_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && phase == PH_WAIT_HI && !bus_hi) |=> !scl_pull_low);  // R5
  AST_HIGH_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && bus_rise) |=> !scl_pull_low);  // R3

endmodule

// File: tb/sim_scl_sync_gen.sv
module sim_scl_sync_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 6;
  localparam int CAP        = 500;
  localparam int NV         = 6;
  // stimulus high/low counts and expected phase lengths
  localparam int VH [NV] = '{3, 1, 7, 0, 63, 2};
  localparam int VL [NV] = '{5, 1, 2, 0, 63, 9};
  localparam int EH [NV] = '{3, 1, 7, 1, 63, 2};
  localparam int EL [NV] = '{5, 1, 2, 1, 63, 9};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic other_pull = 1'b0;
  logic [CNT_W-1:0] high_cnt = '0;
  logic [CNT_W-1:0] low_cnt = '0;
  logic scl_in, scl_pull_low, rise_stb, fall_stb;
  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // wired-AND bus: low if either device pulls
  assign scl_in = !scl_pull_low && !other_pull;

  scl_sync_gen #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl_in),
    .high_cnt(high_cnt), .low_cnt(low_cnt),
    .scl_pull_low(scl_pull_low), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_rise(output int w);
    w = 0;
    do begin @(negedge clk); w++; end while (!rise_stb && w < CAP);
  endtask

  task automatic wait_fall(output int w);
    w = 0;
    do begin @(negedge clk); w++; end while (!fall_stb && w < CAP);
  endtask

  // count following sampled cycles with pull_low == lvl
  task automatic run_len(input logic lvl, output int n);
    n = 0;
    @(negedge clk);
    while (scl_pull_low == lvl && n < CAP) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    int w, n, pc, sc;
    // R1 reset state
    repeat (4) @(negedge clk);
    check(!scl_pull_low && !rise_stb && !fall_stb, "R1 in reset",
          {scl_pull_low, rise_stb, fall_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!scl_pull_low && !rise_stb && !fall_stb, "R1 after reset",
          {scl_pull_low, rise_stb, fall_stb}, 0);

    // R8 first high phase after enable
    high_cnt = 6'd4; low_cnt = 6'd3;
    enable = 1'b1;
    run_len(1'b0, n);
    check(n == 4, "R8 first high after enable", n, 4);

    // R2 strobe width
    wait_fall(w);
    @(negedge clk);
    check(!fall_stb, "R2 fall strobe one cycle", fall_stb, 0);
    wait_rise(w);
    @(negedge clk);
    check(!rise_stb, "R2 rise strobe one cycle", rise_stb, 0);

    // R3 R4 R9 vector table
    for (int i = 0; i < NV; i++) begin
      high_cnt = CNT_W'(VH[i]);
      low_cnt  = CNT_W'(VL[i]);
      wait_fall(w);
      run_len(1'b1, n);
      check(n == EL[i], (VL[i] == 0) ? "R9 zero low count" : "R4 low length", n, EL[i]);
      wait_rise(w);
      run_len(1'b0, n);
      check(n == EH[i], (VH[i] == 0) ? "R9 zero high count" : "R3 high length", n, EH[i]);
    end

    // R5 R6 stretched low phase
    high_cnt = 6'd4; low_cnt = 6'd3;
    wait_fall(w);
    other_pull = 1'b1;
    pc = 0; sc = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (scl_pull_low) pc++;
      if (rise_stb || fall_stb) sc++;
    end
    check(pc == 3, "R4 low count from observed fall", pc, 3);
    check(sc == 0, "R5 no strobe while stretched", sc, 0);
    check(!scl_pull_low, "R5 released while stretched", scl_pull_low, 0);
    other_pull = 1'b0;
    wait_rise(w);
    run_len(1'b0, n);
    check(n == 4, "R6 high after stretch", n, 4);

    // R7 early fall by another master
    high_cnt = 6'd20; low_cnt = 6'd3;
    wait_rise(w);
    @(negedge clk);
    other_pull = 1'b1;
    wait_fall(w);
    check(w <= 3, "R7 early fall seen", w, 3);
    run_len(1'b1, n);
    check(n == 3, "R7 low after early fall", n, 3);
    other_pull = 1'b0;

    // R8 disable while pulling low
    high_cnt = 6'd5; low_cnt = 6'd10;
    wait_fall(w);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(!scl_pull_low, "R8 release on disable", scl_pull_low, 0);
    sc = 0;
    for (int k = 0; k < 24; k++) begin
      if (k % 6 == 0) other_pull = ~other_pull;
      @(negedge clk);
      if (rise_stb || fall_stb || scl_pull_low) sc++;
    end
    check(sc == 0, "R8 quiet while disabled", sc, 0);
    other_pull = 1'b0;
    repeat (5) @(negedge clk);
    enable = 1'b1;
    run_len(1'b0, n);
    check(n == 5, "R8 counter restart on enable", n, 5);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule